// File: doc/BRIEF.md
# Transceiver Interrupt Mask and Aggregation Unit

This unit collects single-cycle event pulses from the monitors inside an Ethernet transceiver and turns them into one interrupt line for the station management side. The monitors cover link and carrier integrity, descrambler synchronization, premature frame end, three error counters overflowing, loopback fault, reset completion, jabber and auto-negotiation events. Each pulse sets a sticky bit in a status register. The interrupt line is raised when a set status bit also has its enable set in a 16-bit mask register.

Software reaches both registers through a simple register port that takes a 5-bit register number. The mask is at register 10h and is read/write. The status is at register 11h, is read-only, and clears when it is read. A compatibility-mode input, which stands for a bit held in another configuration register, freezes three of the mask enables and removes them from the interrupt. The mask only gates the interrupt line. Events are always recorded in the status register, whatever the mask holds.

Top module: `phy_irq_agg`

## Requirements
- R1: After reset the mask reads 16'h4000, with only the link-change enable set. The status reads 16'h0000 and `irq_o` is low.
- R2: An event pulse on `ev_i[n]` (n from 1 to 15) at a rising clock edge sets status bit n from that edge on. The bit stays set until the status register is read, whatever the mask holds. The bit positions are: 15 carrier unstable, 14 link change, 13 descrambler lock change, 12 premature end, 11 disconnect counter overflow, 10 false-carrier counter overflow, 9 receive-error counter overflow, 8 loopback fault, 7 reset done, 6 jabber, 5 auto-negotiation done, 4 parallel detection fault, 3 parallel fail, 2 remote fault, 1 page received.
- R3: `irq_o` is high exactly when some status bit and its effective mask bit are both 1. A status bit whose mask bit is 0 never raises `irq_o`.
- R4: A read of register 11h returns the current status in the same cycle and clears it at the next edge. A bit whose event arrives at that same edge stays set.
- R5: A write to register 10h loads the mask at the next edge. Bit 0 of both registers always reads 0 and ignores writes and events.
- R6: While `compat_i` is 1, a write to register 10h leaves mask bits 14, 13 and 12 unchanged and loads all the other bits.
- R7: While `compat_i` is 1, mask bits 14, 13 and 12 do not contribute to `irq_o`. When `compat_i` returns to 0 they contribute again.
- R8: A read of any register other than 10h and 11h returns 0. A write to any such register, or to the read-only 11h, changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | 16 | Event pulses from the monitors, one bit for each status position |
| compat_i | input | 1 | Compatibility mode, which locks mask bits 14..12 |
| reg_addr_i | input | 5 | Register number |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe; a status read clears the status |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid in the cycle of the strobe |
| irq_o | output | 1 | Interrupt output |

## Verification
The assertions check these properties on every cycle:
- Status bits stay set until a status read.
- Every incoming event is captured.
- The locked mask bits do not move under writes made in compatibility mode.
- Writes to other registers leave the mask untouched.
- The interrupt line never rises without a set status bit, and it stays low in compatibility mode when only locked sources are pending.

Only the bench scenarios can show the rest:
- The exact values read back.
- The clear-on-read race with a new event.
- The bit-position map.
- The interrupt returning when compatibility mode is dropped.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] MASK_ADDR = 5'h10;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 5'h11;
  localparam logic [REG_W-1:0] MASK_RST  = 16'h4000;
  localparam logic [REG_W-1:0] LOCK_BITS = 16'h7000;
  localparam logic [REG_W-1:0] RSVD_BITS = 16'h0001;

  typedef logic [REG_W-1:0] reg_t;

  // Next mask value after a write: locked bits are kept while compat is set
  function automatic reg_t f_mask_write(reg_t old_v, reg_t wd, logic compat);
    reg_t keep;
    keep = compat ? LOCK_BITS : '0;
    return ((old_v & keep) | (wd & ~keep)) & ~RSVD_BITS;
  endfunction

  // Mask as seen by the interrupt gate
  function automatic reg_t f_eff_mask(reg_t m, logic compat);
    return compat ? (m & ~LOCK_BITS) : m;
  endfunction

  // Sticky update: a clear drops bits, new events win
  function automatic reg_t f_status_next(reg_t old_v, reg_t ev, logic clr);
    return ((clr ? '0 : old_v) | ev) & ~RSVD_BITS;
  endfunction
endpackage

// File: rtl/phy_irq_mask_reg.sv
module phy_irq_mask_reg
  import phy_irq_pkg::*;
#(
  parameter int   W        = REG_W,
  parameter logic [W-1:0] RST_VAL = MASK_RST
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         compat,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] eff_mask
);
  always_ff @(posedge clk) begin
    if (!rst_n)  mask_q <= RST_VAL;
    else if (we) mask_q <= f_mask_write(mask_q, wdata, compat);
  end

  assign eff_mask = f_eff_mask(mask_q, compat);

  // R6: locked enables hold across a write made in compat mode
  p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && compat) |=> ((mask_q & LOCK_BITS) == ($past(mask_q) & LOCK_BITS)));

  // R5: reserved bit never becomes set by a write
  p_rsvd_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata[0]) |=> !mask_q[0]);

  // R8: without a write strobe the mask is unchanged
  p_no_stray_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mask_q));
endmodule

// File: rtl/phy_irq_status_reg.sv
module phy_irq_status_reg
  import phy_irq_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic         clr,
  output logic [W-1:0] status_q
);
  logic [W-1:0] ev_used;
  logic [W-1:0] status_d;

  assign ev_used  = ev & ~RSVD_BITS;
  assign status_d = f_status_next(status_q, ev_used, clr);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (RSVD_BITS[i]) begin : g_rsvd
      always_ff @(posedge clk) status_q[i] <= 1'b0;
    end else begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n) status_q[i] <= 1'b0;
        else        status_q[i] <= status_d[i];
      end
    end
  end

  // R2: set bits persist unless a status read clears them
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (($past(status_q) & ~status_q) == '0));

  // R2, R4: every event is captured, even during a clear
  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_used) |=> ((status_q & $past(ev_used)) == $past(ev_used)));
endmodule

// File: rtl/phy_irq_rd_mux.sv
module phy_irq_rd_mux
  import phy_irq_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int AW = ADDR_W
) (
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  mask_q,
  input  logic [W-1:0]  status_q,
  output logic [W-1:0]  rdata,
  output logic          stat_rd
);
  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (addr)
        MASK_ADDR: rdata = mask_q;
        STAT_ADDR: rdata = status_q;
        default:   rdata = '0;
      endcase
    end
  end

  assign stat_rd = rd && (addr == STAT_ADDR);
endmodule

// File: rtl/phy_irq_agg.sv
module phy_irq_agg
  import phy_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  ev_i,
  input  logic              compat_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  logic [REG_W-1:0] mask_q;
  logic [REG_W-1:0] eff_mask;
  logic [REG_W-1:0] status_q;
  logic [REG_W-1:0] pending;
  logic             mask_we;
  logic             stat_rd;

  assign mask_we = reg_wr_i && (reg_addr_i == MASK_ADDR);

  phy_irq_mask_reg #(.W(REG_W), .RST_VAL(MASK_RST)) u_mask (
    .clk(clk), .rst_n(rst_n), .we(mask_we), .wdata(reg_wdata_i),
    .compat(compat_i), .mask_q(mask_q), .eff_mask(eff_mask)
  );

  phy_irq_status_reg #(.W(REG_W)) u_status (
    .clk(clk), .rst_n(rst_n), .ev(ev_i), .clr(stat_rd), .status_q(status_q)
  );

  phy_irq_rd_mux #(.W(REG_W), .AW(ADDR_W)) u_rd (
    .rd(reg_rd_i), .addr(reg_addr_i), .mask_q(mask_q), .status_q(status_q),
    .rdata(reg_rdata_o), .stat_rd(stat_rd)
  );

  assign pending = status_q & eff_mask;
  assign irq_o   = |pending;

  // R3: the line needs a recorded event behind it
  p_irq_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_q != '0));

  // R7: in compat mode only unlocked sources may raise the line
  p_compat_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (compat_i && ((status_q & ~LOCK_BITS) == '0)) |-> !irq_o);

  // R1: state right after reset
  p_reset_state_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (mask_q == MASK_RST && status_q == '0 && !irq_o));
endmodule

// File: tb/tb_phy_irq_agg.sv
module tb_phy_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] ev_i;
  logic        compat_i;
  logic [4:0]  reg_addr_i;
  logic        reg_wr_i, reg_rd_i;
  logic [15:0] reg_wdata_i;
  logic [15:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  phy_irq_agg dut (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .compat_i(compat_i),
    .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [1:0]  op;      // 0 idle, 1 write, 2 read
    logic [4:0]  addr;
    logic [15:0] wd;
    logic [15:0] ev;
    logic        compat;
    logic [15:0] exp_rd;  // checked in the strobe cycle of reads
    logic        exp_irq; // checked after the edge
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 5'h10, 16'h0000, 16'h0000, 1'b0, 16'h4000, 1'b0}, // R1 mask reset
    '{2'd0, 5'h00, 16'h0000, 16'h0020, 1'b0, 16'h0000, 1'b0}, // R3 masked event
    '{2'd2, 5'h11, 16'h0000, 16'h0000, 1'b0, 16'h0020, 1'b0}, // R2 recorded anyway
    '{2'd0, 5'h00, 16'h0000, 16'h4000, 1'b0, 16'h0000, 1'b1}, // R3 enabled event
    '{2'd2, 5'h11, 16'h0000, 16'h0004, 1'b0, 16'h4000, 1'b0}, // R4 race on clear
    '{2'd1, 5'h10, 16'h0005, 16'h0000, 1'b0, 16'h0000, 1'b1}, // R5 write mask
    '{2'd2, 5'h10, 16'h0000, 16'h0000, 1'b0, 16'h0004, 1'b1}, // R5 bit0 dropped
    '{2'd2, 5'h11, 16'h0000, 16'h0000, 1'b0, 16'h0004, 1'b0}, // R4 clear on read
    '{2'd1, 5'h11, 16'hFFFF, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R8 write RO
    '{2'd2, 5'h11, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R8 still zero
    '{2'd1, 5'h05, 16'hFFFF, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R8 unmapped wr
    '{2'd2, 5'h10, 16'h0000, 16'h0000, 1'b0, 16'h0004, 1'b0}, // R8 mask intact
    '{2'd2, 5'h1F, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R8 unmapped rd
    '{2'd1, 5'h10, 16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b0}, // R6 compat write
    '{2'd2, 5'h10, 16'h0000, 16'h0000, 1'b1, 16'h8FFE, 1'b0}, // R6 locked held
    '{2'd0, 5'h00, 16'h0000, 16'h8000, 1'b1, 16'h0000, 1'b1}, // R7 unlocked ok
    '{2'd2, 5'h11, 16'h0000, 16'h0000, 1'b1, 16'h8000, 1'b0}  // R4 clear
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ev_i = '0; reg_wr_i = 0; reg_rd_i = 0; reg_addr_i = '0; reg_wdata_i = '0;
  endtask

  // one-cycle register access; returns read data sampled in the strobe cycle
  task automatic access(input logic wr, input logic rd, input logic [4:0] a,
                        input logic [15:0] d, input logic [15:0] ev,
                        output logic [15:0] rdv);
    @(negedge clk);
    reg_wr_i = wr; reg_rd_i = rd; reg_addr_i = a; reg_wdata_i = d; ev_i = ev;
    #5 rdv = reg_rdata_o;
    @(posedge clk); #1;
    @(negedge clk); idle();
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] rv;
    idle(); compat_i = 0; rst_n = 0;
    repeat (3) @(posedge clk);
    #1 chk("R1 irq in reset", {15'd0, irq_o}, 16'h0);
    @(negedge clk) rst_n = 1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      reg_wr_i = (VEC[i].op == 2'd1); reg_rd_i = (VEC[i].op == 2'd2);
      reg_addr_i = VEC[i].addr; reg_wdata_i = VEC[i].wd;
      ev_i = VEC[i].ev; compat_i = VEC[i].compat;
      #5;
      if (VEC[i].op == 2'd2)
        chk($sformatf("vec %0d rdata (R1/R4/R5/R6/R8)", i), reg_rdata_o, VEC[i].exp_rd);
      @(posedge clk); #1;
      chk($sformatf("vec %0d irq (R3/R7)", i), {15'd0, irq_o}, {15'd0, VEC[i].exp_irq});
    end
    @(negedge clk); idle(); compat_i = 0;

    // R1: fresh reset restores defaults
    rst_n = 0; @(posedge clk); @(negedge clk); rst_n = 1;
    access(0, 1, 5'h11, 0, 0, rv); chk("R1 status reset", rv, 16'h0000);
    access(0, 1, 5'h10, 0, 0, rv); chk("R1 mask reset", rv, 16'h4000);

    // R2: bit map, one source at a time; bit 0 never records (R5)
    for (int n = 0; n < 16; n++) begin
      access(0, 0, 5'h00, 0, 16'(1) << n, rv);
      access(0, 1, 5'h11, 0, 0, rv);
      chk($sformatf("R2 bit %0d position", n), rv, (n == 0) ? 16'h0 : (16'(1) << n));
    end

    // R2: link change both directions, sticky across many cycles
    access(0, 0, 5'h00, 0, 16'h4000, rv);
    repeat (5) @(posedge clk);
    access(0, 0, 5'h00, 0, 16'h4000, rv);
    chk("R2 irq held", {15'd0, irq_o}, 16'h1);
    access(0, 1, 5'h11, 0, 0, rv); chk("R2 sticky link change", rv, 16'h4000);
    chk("R3 irq drops after clear", {15'd0, irq_o}, 16'h0);

    // R7: locked source pending, compat hides it, release shows it
    @(negedge clk) compat_i = 1;
    access(0, 0, 5'h00, 0, 16'h4000, rv);
    chk("R7 locked source silent", {15'd0, irq_o}, 16'h0);
    @(negedge clk) compat_i = 0; #5;
    chk("R7 returns when compat off", {15'd0, irq_o}, 16'h1);
    @(negedge clk) compat_i = 1;
    // R6: clearing write in compat mode keeps bit 14
    access(1, 0, 5'h10, 16'h0000, 0, rv);
    access(0, 1, 5'h10, 0, 0, rv); chk("R6 bit14 kept", rv, 16'h4000);
    @(negedge clk) compat_i = 0; #5;
    chk("R3 irq with mask 14", {15'd0, irq_o}, 16'h1);
    access(0, 1, 5'h11, 0, 0, rv); chk("R4 status read", rv, 16'h4000);
    access(0, 1, 5'h11, 0, 0, rv); chk("R4 cleared", rv, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule